// File: doc/BRIEF.md
# I2C Start/Stop Condition Controller

This block turns the two software request flags of an I2C interface, "start wanted" and "stop wanted", into START, repeated START and STOP conditions on the open-drain SDA and SCL lines. It watches the synchronised bus lines to know whether any master holds the bus. A START on a free bus goes out at once. On a busy bus the request waits for the other master's STOP and then for one half-period tick of the serial clock generator. Once the block is master, it can insert a repeated START between bytes and it closes the transfer with a STOP.

A stop request made while the block is not master never reaches the wires. The block acts as though a STOP had been received instead: it drops its bus-busy flag, signals a one-cycle reset of the slave logic to the not-addressed receiver state and clears the request. Byte shifting, acknowledge handling and address matching sit in neighbouring blocks. The block only learns from the shifter that a byte has completed (`byte_done`).

The controller state machine has these states. `CS_IDLE` waits for a request. `CS_WAIT_STOP` waits for a foreign STOP. `CS_WAIT_HALF` waits for the half-period tick after a STOP. `CS_START_LOW` pulls SDA low with SCL high. `CS_HOLD` is master and holds SCL low. `CS_RS_RELEASE` and `CS_RS_RAISE` release SDA and then SCL before a repeated START. `CS_STOP_LOW`, `CS_STOP_RAISE` and `CS_STOP_RELEASE` form the STOP sequence. `CS_RECOVER` is the local slave reset.

The transitions are:
- IDLE→START_LOW when the start flag is set and the bus is free.
- IDLE→WAIT_STOP when the start flag is set and the bus is busy.
- WAIT_STOP→WAIT_HALF on a detected STOP.
- WAIT_HALF→START_LOW on a tick with the start flag still set.
- WAIT_HALF→IDLE on a tick with the start flag cleared.
- WAIT_HALF→WAIT_STOP when the bus turns busy again.
- WAIT_STOP→IDLE when the start flag is withdrawn.
- START_LOW→HOLD on a tick.
- HOLD→RS_RELEASE→RS_RAISE→START_LOW for a repeated START.
- HOLD→STOP_LOW→STOP_RAISE→STOP_RELEASE, then STOP_RELEASE→WAIT_HALF on a detected STOP.
- IDLE, WAIT_STOP or WAIT_HALF→RECOVER when a stop request is pending, then RECOVER→IDLE.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset, `sda_oe`, `scl_oe`, `is_master`, `bus_busy`, `sto_flag` and `slave_rst` are all 0.
- R2: While `enable` is 0, both line drives are released within one cycle and no condition appears on the bus. A `sto_set` pulse leaves `sto_flag` at 0.
- R3: `bus_busy` becomes 1 after a START (SDA falling while SCL is high) is seen on the bus. It becomes 0 after a STOP (SDA rising while SCL is high) is seen.
- R4: With `sta`=1 on a free bus, the block pulls SDA low while SCL stays released. After a half-period tick it pulls SCL low and `is_master` becomes 1.
- R5: With `sta`=1 on a busy bus while not master, the block drives neither line until a STOP appears. Its START falls no earlier than the first `half_tick` after that STOP.
- R6: As master, with `sta`=1 and at least one `byte_done` since the last START, the block releases SDA, then SCL, and issues a repeated START. It stays master.
- R7: As master, no START is issued when `sta`=0, or when no `byte_done` has occurred since the last START.
- R8: A `sto_set` in master mode drives a STOP (SDA rising while SCL is high). `sto_flag` returns to 0 and `is_master` becomes 0 once that STOP has been detected.
- R9: A `sto_set` while not master produces no line drive. It gives exactly one `slave_rst` pulse and clears `sto_flag` and `bus_busy`.
- R10: When stop and start are requested together in master mode, the STOP appears on the bus first and the START follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable; 0 holds the controller idle |
| sta | input | 1 | Software start-request flag (level) |
| sto_set | input | 1 | One-cycle pulse that sets the stop-request flag |
| byte_done | input | 1 | One-cycle pulse from the shifter at the end of a byte |
| half_tick | input | 1 | One-cycle pulse once per half serial-clock period |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| is_master | output | 1 | Block currently owns the bus as master |
| bus_busy | output | 1 | A START has been seen with no STOP since |
| sto_flag | output | 1 | Pending stop request, cleared by hardware |
| slave_rst | output | 1 | One-cycle pulse: slave logic to not-addressed receiver |

## Verification
Two behaviours are hard to reach from the ports: the deferred START and the silent slave recovery. Both need the bus busy while this block is not master. The bench therefore acts as a second open-drain master on the wired lines. It opens and closes transfers with its own SDA and SCL pulls. It counts the half-period ticks it hands out, so it can show that the deferred START falls only after a tick that follows the foreign STOP. During the recovery it records every drive the block makes.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [3:0] {
        CS_IDLE,
        CS_WAIT_STOP,
        CS_WAIT_HALF,
        CS_START_LOW,
        CS_HOLD,
        CS_RS_RELEASE,
        CS_RS_RAISE,
        CS_STOP_LOW,
        CS_STOP_RAISE,
        CS_STOP_RELEASE,
        CS_RECOVER
    } cond_state_e;

    typedef struct packed {
        logic sda_low;
        logic scl_low;
    } line_drive_t;

    // Line pulls belonging to each state (1 = pull low)
    function automatic line_drive_t drive_for(cond_state_e s);
        line_drive_t d;
        d = '{sda_low: 1'b0, scl_low: 1'b0};
        unique case (s)
            CS_START_LOW:  d = '{sda_low: 1'b1, scl_low: 1'b0};
            CS_HOLD:       d = '{sda_low: 1'b0, scl_low: 1'b1};
            CS_RS_RELEASE: d = '{sda_low: 1'b0, scl_low: 1'b1};
            CS_STOP_LOW:   d = '{sda_low: 1'b1, scl_low: 1'b1};
            CS_STOP_RAISE: d = '{sda_low: 1'b1, scl_low: 1'b0};
            CS_IDLE, CS_WAIT_STOP, CS_WAIT_HALF, CS_RS_RAISE,
            CS_STOP_RELEASE, CS_RECOVER:
                d = '{sda_low: 1'b0, scl_low: 1'b0};
            default:       d = '{sda_low: 1'b0, scl_low: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_cond_busmon.sv
module i2c_cond_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    input  logic scl_in,
    input  logic busy_clr,
    output logic stop_det,
    output logic bus_busy
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sda_pipe;
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic                   sda_prev;
    logic                   scl_prev;
    logic                   start_det;

    // Synchroniser chain, idle-high reset values
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        sda_pipe[0] <= 1'b1;
                        scl_pipe[0] <= 1'b1;
                    end else begin
                        sda_pipe[0] <= sda_in;
                        scl_pipe[0] <= scl_in;
                    end
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        sda_pipe[g] <= 1'b1;
                        scl_pipe[g] <= 1'b1;
                    end else begin
                        sda_pipe[g] <= sda_pipe[g-1];
                        scl_pipe[g] <= scl_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_prev <= 1'b1;
            scl_prev <= 1'b1;
        end else begin
            sda_prev <= sda_pipe[LAST];
            scl_prev <= scl_pipe[LAST];
        end
    end

    // SDA edge while SCL is high on both samples
    always_comb begin
        start_det = sda_prev & ~sda_pipe[LAST] & scl_prev & scl_pipe[LAST];
        stop_det  = ~sda_prev & sda_pipe[LAST] & scl_prev & scl_pipe[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_busy <= 1'b0;
        end else if (busy_clr || stop_det) begin
            bus_busy <= 1'b0;
        end else if (start_det) begin
            bus_busy <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_cond_flags.sv
module i2c_cond_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sto_set,
    input  logic sto_clr,
    input  logic byte_done,
    input  logic is_master,
    input  logic start_done,
    output logic sto_flag,
    output logic bytes_seen
);

    // Stop request: software sets, hardware clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sto_flag <= 1'b0;
        end else if (!enable) begin
            sto_flag <= 1'b0;
        end else if (sto_set) begin
            sto_flag <= 1'b1;
        end else if (sto_clr) begin
            sto_flag <= 1'b0;
        end
    end

    // A byte moved since the last START completed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_seen <= 1'b0;
        end else if (!enable || start_done) begin
            bytes_seen <= 1'b0;
        end else if (byte_done && is_master) begin
            bytes_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
    import i2c_cond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sta,
    input  logic sto_flag,
    input  logic bytes_seen,
    input  logic bus_busy,
    input  logic stop_det,
    input  logic half_tick,
    output logic sda_oe,
    output logic scl_oe,
    output logic is_master,
    output logic start_done,
    output logic sto_clr,
    output logic slave_rst
);

    cond_state_e st, st_nxt;
    logic        master_nxt;
    line_drive_t drv;

    // Next-state logic
    always_comb begin
        st_nxt = st;
        if (!enable) begin
            st_nxt = CS_IDLE;
        end else begin
            unique case (st)
                CS_IDLE: begin
                    if (sto_flag)      st_nxt = CS_RECOVER;
                    else if (sta)      st_nxt = bus_busy ? CS_WAIT_STOP : CS_START_LOW;
                end
                CS_WAIT_STOP: begin
                    if (sto_flag)      st_nxt = CS_RECOVER;
                    else if (!sta)     st_nxt = CS_IDLE;
                    else if (stop_det) st_nxt = CS_WAIT_HALF;
                end
                CS_WAIT_HALF: begin
                    if (sto_flag)       st_nxt = CS_RECOVER;
                    else if (bus_busy)  st_nxt = CS_WAIT_STOP;
                    else if (half_tick) st_nxt = sta ? CS_START_LOW : CS_IDLE;
                end
                CS_START_LOW: begin
                    if (half_tick)     st_nxt = CS_HOLD;
                end
                CS_HOLD: begin
                    if (sto_flag)                st_nxt = CS_STOP_LOW;
                    else if (sta && bytes_seen)  st_nxt = CS_RS_RELEASE;
                end
                CS_RS_RELEASE: begin
                    if (half_tick)     st_nxt = CS_RS_RAISE;
                end
                CS_RS_RAISE: begin
                    if (half_tick)     st_nxt = CS_START_LOW;
                end
                CS_STOP_LOW: begin
                    if (half_tick)     st_nxt = CS_STOP_RAISE;
                end
                CS_STOP_RAISE: begin
                    if (half_tick)     st_nxt = CS_STOP_RELEASE;
                end
                CS_STOP_RELEASE: begin
                    if (stop_det)      st_nxt = CS_WAIT_HALF;
                end
                CS_RECOVER: begin
                    st_nxt = CS_IDLE;
                end
                default: st_nxt = CS_IDLE;
            endcase
        end
    end

    always_comb begin
        master_nxt = is_master;
        if (!enable)
            master_nxt = 1'b0;
        else if (st == CS_START_LOW && half_tick)
            master_nxt = 1'b1;
        else if (st == CS_STOP_RELEASE && stop_det)
            master_nxt = 1'b0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= CS_IDLE;
            is_master <= 1'b0;
        end else begin
            st        <= st_nxt;
            is_master <= master_nxt;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        drv        = drive_for(st);
        sda_oe     = drv.sda_low;
        scl_oe     = drv.scl_low;
        start_done = enable && (st == CS_START_LOW) && half_tick;
        sto_clr    = (st == CS_RECOVER) || ((st == CS_STOP_RELEASE) && stop_det);
        slave_rst  = (st == CS_RECOVER);
    end

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sta,
    input  logic sto_set,
    input  logic byte_done,
    input  logic half_tick,
    input  logic sda_in,
    input  logic scl_in,
    output logic sda_oe,
    output logic scl_oe,
    output logic is_master,
    output logic bus_busy,
    output logic sto_flag,
    output logic slave_rst
);

    logic stop_det;
    logic bytes_seen;
    logic start_done;
    logic sto_clr;

    i2c_cond_busmon #(.SYNC_STAGES(SYNC_STAGES)) busmon_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_in   (sda_in),
        .scl_in   (scl_in),
        .busy_clr (slave_rst),
        .stop_det (stop_det),
        .bus_busy (bus_busy)
    );

    i2c_cond_flags flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sto_set    (sto_set),
        .sto_clr    (sto_clr),
        .byte_done  (byte_done),
        .is_master  (is_master),
        .start_done (start_done),
        .sto_flag   (sto_flag),
        .bytes_seen (bytes_seen)
    );

    i2c_cond_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sta        (sta),
        .sto_flag   (sto_flag),
        .bytes_seen (bytes_seen),
        .bus_busy   (bus_busy),
        .stop_det   (stop_det),
        .half_tick  (half_tick),
        .sda_oe     (sda_oe),
        .scl_oe     (scl_oe),
        .is_master  (is_master),
        .start_done (start_done),
        .sto_clr    (sto_clr),
        .slave_rst  (slave_rst)
    );

endmodule

// File: rtl/i2c_cond_ctrl_chk.sv
module i2c_cond_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic sda_oe,
    input logic scl_oe,
    input logic is_master,
    input logic bus_busy,
    input logic sto_flag,
    input logic slave_rst,
    input logic stop_det
);

    AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sda_oe && !scl_oe)); // R2

    AST_SCL_ONLY_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> is_master); // R4

    AST_START_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !is_master) |-> !bus_busy); // R5

    AST_STO_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sto_flag) |-> ($past(stop_det) || $past(slave_rst) || $past(!enable))); // R8

    AST_RECOVER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        slave_rst |-> (!sda_oe && !scl_oe && !is_master)); // R9

    AST_RECOVER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        slave_rst |=> (!slave_rst && !sto_flag && !bus_busy)); // R9

endmodule

bind i2c_cond_ctrl i2c_cond_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sda_oe    (sda_oe),
    .scl_oe    (scl_oe),
    .is_master (is_master),
    .bus_busy  (bus_busy),
    .sto_flag  (sto_flag),
    .slave_rst (slave_rst),
    .stop_det  (stop_det)
);

// File: tb/i2c_cond_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_cond_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic sta = 1'b0;
    logic sto_set = 1'b0;
    logic byte_done = 1'b0;
    logic half_tick = 1'b0;
    logic ext_sda_low = 1'b0;
    logic ext_scl_low = 1'b0;
    logic sda_oe, scl_oe, is_master, bus_busy, sto_flag, slave_rst;
    logic bus_sda, bus_scl;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tick_cnt = 0;
    int start_cnt = 0;
    int stop_cnt = 0;
    int last_start_cyc = 0;
    int last_stop_cyc = 0;
    logic prev_sda = 1'b1;
    logic prev_scl = 1'b1;

    always #2 clk = ~clk; // 250 MHz

    assign bus_sda = !sda_oe && !ext_sda_low;
    assign bus_scl = !scl_oe && !ext_scl_low;

    i2c_cond_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sta(sta),
        .sto_set(sto_set), .byte_done(byte_done), .half_tick(half_tick),
        .sda_in(bus_sda), .scl_in(bus_scl), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .is_master(is_master), .bus_busy(bus_busy), .sto_flag(sto_flag),
        .slave_rst(slave_rst)
    );

    // Half-period tick every 10 cycles, bus condition monitor
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if ((cyc % 10) == 9) begin
            half_tick <= 1'b1;
            tick_cnt  <= tick_cnt + 1;
        end else begin
            half_tick <= 1'b0;
        end
        if (prev_sda && !bus_sda && prev_scl && bus_scl) begin
            start_cnt <= start_cnt + 1;
            last_start_cyc <= cyc;
        end
        if (!prev_sda && bus_sda && prev_scl && bus_scl) begin
            stop_cnt <= stop_cnt + 1;
            last_stop_cyc <= cyc;
        end
        prev_sda <= bus_sda;
        prev_scl <= bus_scl;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_sto();
        @(negedge clk); sto_set = 1'b1;
        @(negedge clk); sto_set = 1'b0;
    endtask

    task automatic ext_start();
        ext_sda_low = 1'b1; wait_cyc(6);
        ext_scl_low = 1'b1; wait_cyc(10);
    endtask

    task automatic ext_stop();
        ext_sda_low = 1'b1; wait_cyc(4);
        ext_scl_low = 1'b0; wait_cyc(6);
        ext_sda_low = 1'b0;
    endtask

    task automatic t_reset();
        check(!sda_oe && !scl_oe, "R1 drives", {sda_oe, scl_oe}, 0);
        check(!is_master && !bus_busy, "R1 status", {is_master, bus_busy}, 0);
        check(!sto_flag && !slave_rst, "R1 flags", {sto_flag, slave_rst}, 0);
    endtask

    task automatic t_disabled();
        int s0 = start_cnt;
        int drv = 0;
        sta = 1'b1;
        sto_set = 1'b1; @(negedge clk); sto_set = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sda_oe || scl_oe) drv++;
        end
        check(drv == 0, "R2 no drive while disabled", drv, 0);
        check(start_cnt == s0, "R2 no START while disabled", start_cnt, s0);
        check(!sto_flag, "R2 sto_set ignored", sto_flag, 0);
    endtask

    task automatic t_free_start();
        int s0 = start_cnt;
        enable = 1'b1;
        for (int i = 0; i < 60 && !is_master; i++) @(negedge clk);
        check(start_cnt == s0 + 1, "R4 START issued", start_cnt, s0 + 1);
        check(is_master && scl_oe, "R4 master holding SCL", {is_master, scl_oe}, 3);
        wait_cyc(4);
        check(bus_busy, "R3 busy after START", bus_busy, 1);
    endtask

    task automatic t_no_rs();
        int s0 = start_cnt;
        wait_cyc(80);
        check(start_cnt == s0, "R7 no Sr without byte", start_cnt, s0);
        sta = 1'b0;
        @(negedge clk); byte_done = 1'b1; @(negedge clk); byte_done = 1'b0;
        wait_cyc(80);
        check(start_cnt == s0, "R7 no Sr with sta low", start_cnt, s0);
    endtask

    task automatic t_rs();
        int s0 = start_cnt;
        int p0 = stop_cnt;
        sta = 1'b1;
        wait_cyc(80);
        check(start_cnt == s0 + 1, "R6 repeated START", start_cnt, s0 + 1);
        check(stop_cnt == p0 && is_master, "R6 stays master", stop_cnt, p0);
        sta = 1'b0;
    endtask

    task automatic t_master_stop();
        int p0 = stop_cnt;
        pulse_sto();
        check(sto_flag, "R8 sto_flag set", sto_flag, 1);
        wait_cyc(80);
        check(stop_cnt == p0 + 1, "R8 STOP on bus", stop_cnt, p0 + 1);
        check(!sto_flag && !is_master, "R8 flag and master cleared", {sto_flag, is_master}, 0);
        check(!bus_busy, "R3 busy cleared by STOP", bus_busy, 0);
    endtask

    task automatic t_busy_wait();
        int drv = 0;
        int t0;
        int tn = 0;
        int i;
        ext_start();
        check(bus_busy, "R3 busy on foreign START", bus_busy, 1);
        sta = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (sda_oe || scl_oe) drv++;
        end
        check(drv == 0, "R5 no drive while bus busy", drv, 0);
        ext_stop();
        t0 = tick_cnt;
        for (i = 0; i < 100 && !sda_oe; i++) @(negedge clk);
        tn = tick_cnt;
        check(sda_oe && (tn > t0), "R5 START after tick following STOP", tn, t0 + 1);
        for (int k = 0; k < 40 && !is_master; k++) @(negedge clk);
        check(is_master, "R5 master after deferred START", is_master, 1);
        sta = 1'b0;
        pulse_sto();
        wait_cyc(80);
    endtask

    task automatic t_slave_recover();
        int drv = 0;
        int rst_pulses = 0;
        int p0;
        ext_start();
        p0 = stop_cnt;
        check(bus_busy && !is_master, "R9 busy as non-master", {bus_busy, is_master}, 2);
        @(negedge clk); sto_set = 1'b1;
        @(negedge clk); sto_set = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (slave_rst) rst_pulses++;
            if (sda_oe || scl_oe) drv++;
            @(negedge clk);
        end
        check(rst_pulses == 1, "R9 one slave reset pulse", rst_pulses, 1);
        check(drv == 0, "R9 no line drive", drv, 0);
        check(!sto_flag && !bus_busy, "R9 flag and busy cleared", {sto_flag, bus_busy}, 0);
        check(stop_cnt == p0, "R9 no STOP on bus", stop_cnt, p0);
        ext_stop();
        wait_cyc(20);
    endtask

    task automatic t_sta_sto();
        int s0;
        int p0;
        sta = 1'b1;
        for (int k = 0; k < 60 && !is_master; k++) @(negedge clk);
        s0 = start_cnt;
        p0 = stop_cnt;
        pulse_sto();
        wait_cyc(150);
        check(stop_cnt == p0 + 1 && start_cnt == s0 + 1, "R10 STOP and START both sent",
              stop_cnt - p0 + start_cnt - s0, 2);
        check(last_stop_cyc < last_start_cyc, "R10 STOP precedes START", last_stop_cyc, last_start_cyc);
        check(is_master, "R10 master again", is_master, 1);
        sta = 1'b0;
        pulse_sto();
        wait_cyc(80);
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_disabled();
        t_free_start();
        t_no_rs();
        t_rs();
        t_master_stop();
        wait_cyc(20);
        t_busy_wait();
        t_slave_recover();
        t_sta_sto();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule